// File: doc/BRIEF.md
# Two-Bank Transmit Buffer Controller for a USB IN Endpoint

This block holds the transmit data of one device-side IN endpoint in one or two byte banks. It passes each bank back and forth between firmware and the serial packet engine. Firmware sees a transmit-ready flag and an ownership bit. Both are set when the bank at its pointer is free. Firmware acknowledges the flag, fills the bank byte by byte, and then hands it over by issuing a release, which is the same as clearing the ownership bit. When an IN token arrives, the engine streams the oldest handed-over bank, or answers NAK if no bank is waiting. A host ACK returns the bank to firmware.

In two-bank mode, firmware and engine each keep their own bank pointer. Firmware can fill one bank while the other one is being sent. Banks go out in the order they were released. Each time ownership changes, the ready flag and the ownership bit are recomputed from the state of the bank firmware now points at.

Top module: `usb_in_ep_bank_ctrl`

## Requirements
- R1: While `cfg_enable` is low, every status output (`st_ready`, `st_own`, `st_rw_ok`, `ep_irq`, `err_overflow`, `err_release`) is 0 one clock edge later. Every IN token is answered with a one-cycle `tok_nak` after the edge that samples it.
- R2: `st_ready` and `st_own` rise at the same edge whenever the bank at the firmware pointer becomes free for firmware. This includes the first edge after enabling.
- R3: `ep_irq` is high exactly when `st_ready` and `cpu_int_en` are both high.
- R4: A `cpu_clr_ready` pulse clears `st_ready` at the next edge and leaves `st_own` unchanged.
- R5: A `cpu_release` issued while `st_ready` is high, or while firmware does not own a bank, is ignored: ownership and bank contents stay as they were. It also produces a one-cycle `err_release` pulse after the edge.
- R6: A `cpu_release` issued with `st_own` high and `st_ready` low hands the current bank to the engine. In single-bank mode (`cfg_dual`=0), `st_own` and `st_ready` then stay low until that bank is acknowledged.
- R7: In two-bank mode (`cfg_dual`=1), a valid release moves the firmware pointer to the other bank. If that bank is free, `st_own` stays high and `st_ready` is set again at the same edge.
- R8: `st_rw_ok` is high while firmware owns the current bank and that bank holds fewer than `BANK_BYTES` bytes. It goes low at the edge that stores the last byte.
- R9: A `cpu_wr` pulse while `st_rw_ok` is low is dropped. It sets `err_overflow`, which stays set until reset or disable.
- R10: An IN token that arrives while the engine is idle and its bank has not been released gives a one-cycle `tok_nak` after the edge that samples it.
- R11: An IN token that arrives while the engine bank has been released starts the stream on the next cycle. `tx_valid` is high for one cycle per stored byte, the bytes come out in write order, and `tx_last` is high on the final byte.
- R12: A released bank with zero bytes is sent as a single-cycle `tx_zlp` with `tx_valid` low.
- R13: A `host_ack` after a packet frees that bank. In single-bank mode, `st_own` and `st_ready` are high again at the edge that samples the ACK.
- R14: In two-bank mode, the engine sends the banks in the order firmware released them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Endpoint configured; low clears all state |
| cfg_dual | input | 1 | 1 = two banks, 0 = one bank |
| cpu_int_en | input | 1 | Interrupt enable for the ready flag |
| cpu_wr | input | 1 | Write one byte into the current bank |
| cpu_wdata | input | DATA_W | Byte written by firmware |
| cpu_clr_ready | input | 1 | Clear the transmit-ready flag |
| cpu_release | input | 1 | Hand the current bank to the engine |
| st_ready | output | 1 | Transmit-ready flag |
| st_own | output | 1 | Firmware owns the current bank |
| st_rw_ok | output | 1 | Current bank still accepts bytes |
| ep_irq | output | 1 | Endpoint interrupt |
| err_release | output | 1 | Release ignored (pulse) |
| err_overflow | output | 1 | Sticky: a write was dropped |
| tok_in | input | 1 | IN token strobe |
| tok_nak | output | 1 | NAK answer (pulse) |
| host_ack | input | 1 | Host acknowledged the packet |
| tx_valid | output | 1 | Data byte valid |
| tx_data | output | DATA_W | Data byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_zlp | output | 1 | Zero-length packet strobe |

## Verification
The bench goes after an early release attempted while the ready flag is still set. A design that accepted it would send a bank that firmware never acknowledged, and `err_release` would stay quiet. It fills a bank to the brim and then writes once more. A counter that is off by one would either stop one byte short or overwrite the bank, and would miss the sticky overflow. It also releases an empty bank: a design that got this wrong would stream stale bytes or hang instead of sending a zero-length packet. In two-bank mode it checks that the ready flag and ownership survive a release when the other bank is free, and that the two banks leave in release order rather than in pointer order.

// File: rtl/inep_pkg.sv
package inep_pkg;
   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_SEND = 2'd1,
      ENG_WAIT = 2'd2
   } eng_state_t;
endpackage

// File: rtl/inep_bank_store.sv
module inep_bank_store #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 8,
   parameter int NUM_BANKS = 2,
   parameter int CNT_W     = 4,
   parameter int IDX_W     = 3
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        clear_all,
   input  logic                        wr_en,
   input  logic                        wr_bank,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic                        clr_en,
   input  logic                        clr_bank,
   input  logic                        rd_bank,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic [DATA_W-1:0]           rd_data,
   output logic [1:0][CNT_W-1:0]       cnt_o
);
   logic [1:0][DATA_W-1:0] rd_word;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      if (b < NUM_BANKS) begin : g_real
         logic [DATA_W-1:0] mem_q [DEPTH];
         logic [CNT_W-1:0]  cnt_q;

         always_ff @(posedge clk) begin
            if (rst || clear_all) begin
               cnt_q <= '0;
            end else if (clr_en && (clr_bank == 1'(b))) begin
               cnt_q <= '0;
            end else if (wr_en && (wr_bank == 1'(b))) begin
               mem_q[cnt_q[IDX_W-1:0]] <= wr_data;
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end

         assign cnt_o[b]   = cnt_q;
         assign rd_word[b] = mem_q[rd_idx];

         // R8: the controller never stores into a full bank
         a_r8_no_overfill: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_bank == 1'(b))) |-> (cnt_q < CNT_W'(DEPTH)));
      end else begin : g_tie
         assign cnt_o[b]   = '0;
         assign rd_word[b] = '0;
      end
   end

   assign rd_data = rd_word[rd_bank];
endmodule

// File: rtl/inep_fw_ctrl.sv
module inep_fw_ctrl #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             dual,
   input  logic             wr_req,
   input  logic             clr_ready,
   input  logic             release_req,
   input  logic             free_pulse,
   input  logic             free_bank,
   input  logic [CNT_W-1:0] cnt_cur,
   output logic             own_o,
   output logic             ready_o,
   output logic             rw_ok_o,
   output logic             rel_err_o,
   output logic             ovf_o,
   output logic             wr_accept_o,
   output logic             fw_ptr_o,
   output logic [1:0]       released_o
);
   logic       own_q, ready_q, err_q, ovf_q, fw_ptr_q;
   logic [1:0] released_q, released_n;
   logic       rel_ok, keep, own_n, fw_ptr_n, grant, rw_ok;

   assign rw_ok  = own_q && (cnt_cur < CNT_W'(DEPTH));
   assign rel_ok = release_req && own_q && !ready_q;

   always_comb begin
      released_n = released_q;
      if (free_pulse) released_n[free_bank] = 1'b0;
      if (rel_ok)     released_n[fw_ptr_q]  = 1'b1;
   end

   assign fw_ptr_n = (rel_ok && dual) ? ~fw_ptr_q : fw_ptr_q;
   assign keep     = own_q && !rel_ok;
   assign own_n    = keep || !released_n[fw_ptr_n];
   assign grant    = own_n && !keep;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         own_q      <= 1'b0;
         ready_q    <= 1'b0;
         err_q      <= 1'b0;
         ovf_q      <= 1'b0;
         fw_ptr_q   <= 1'b0;
         released_q <= '0;
      end else begin
         own_q      <= own_n;
         ready_q    <= grant ? 1'b1 : (clr_ready ? 1'b0 : ready_q);
         err_q      <= release_req && !rel_ok;
         if (wr_req && !rw_ok) ovf_q <= 1'b1;
         fw_ptr_q   <= fw_ptr_n;
         released_q <= released_n;
      end
   end

   assign own_o       = own_q;
   assign ready_o     = ready_q;
   assign rw_ok_o     = rw_ok;
   assign rel_err_o   = err_q;
   assign ovf_o       = ovf_q;
   assign wr_accept_o = wr_req && rw_ok;
   assign fw_ptr_o    = fw_ptr_q;
   assign released_o  = released_q;

   // R1: disabling clears the firmware flags
   a_r1_off_clears: assert property (@(posedge clk) disable iff (rst)
      !en |=> (!own_q && !ready_q && !ovf_q));
   // R2: ready never rises without ownership
   a_r2_ready_with_own: assert property (@(posedge clk) disable iff (rst)
      $rose(ready_q) |-> own_q);
   // R5: early release reported
   a_r5_early_release: assert property (@(posedge clk) disable iff (rst)
      (en && release_req && ready_q) |=> err_q);
   // R6: single-bank release drops ownership
   a_r6_release_drops_own: assert property (@(posedge clk) disable iff (rst)
      (en && rel_ok && !dual) |=> !own_q);
   // R9: overflow is sticky while enabled
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      (en && ovf_q) |=> ovf_q);
endmodule

// File: rtl/inep_tx_engine.sv
module inep_tx_engine
   import inep_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int IDX_W = 3
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  en,
   input  logic                  dual,
   input  logic                  tok_in,
   input  logic                  host_ack,
   input  logic [1:0]            released,
   input  logic [1:0][CNT_W-1:0] cnt_all,
   output logic                  eng_ptr_o,
   output logic [IDX_W-1:0]      rd_idx_o,
   output logic                  tx_valid,
   output logic                  tx_last,
   output logic                  tx_zlp,
   output logic                  tok_nak,
   output logic                  free_pulse
);
   eng_state_t       st_q;
   logic             eng_ptr_q, nak_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] cnt_e;
   logic             last_beat, empty;

   assign cnt_e     = cnt_all[eng_ptr_q];
   assign empty     = (cnt_e == '0);
   assign last_beat = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_e;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q      <= ENG_IDLE;
         eng_ptr_q <= 1'b0;
         idx_q     <= '0;
         nak_q     <= 1'b0;
      end else if (!en) begin
         st_q      <= ENG_IDLE;
         eng_ptr_q <= 1'b0;
         idx_q     <= '0;
         nak_q     <= tok_in;
      end else begin
         nak_q <= 1'b0;
         unique case (st_q)
            ENG_IDLE: begin
               if (tok_in) begin
                  if (released[eng_ptr_q]) begin
                     st_q  <= ENG_SEND;
                     idx_q <= '0;
                  end else begin
                     nak_q <= 1'b1;
                  end
               end
            end
            ENG_SEND: begin
               if (empty || last_beat) st_q <= ENG_WAIT;
               else                    idx_q <= idx_q + IDX_W'(1);
            end
            ENG_WAIT: begin
               if (host_ack) begin
                  st_q <= ENG_IDLE;
                  if (dual) eng_ptr_q <= ~eng_ptr_q;
               end
            end
            default: st_q <= ENG_IDLE;
         endcase
      end
   end

   assign tx_valid   = (st_q == ENG_SEND) && !empty;
   assign tx_last    = tx_valid && last_beat;
   assign tx_zlp     = (st_q == ENG_SEND) && empty;
   assign tok_nak    = nak_q;
   assign free_pulse = en && (st_q == ENG_WAIT) && host_ack;
   assign eng_ptr_o  = eng_ptr_q;
   assign rd_idx_o   = idx_q;

   // R10: a waiting bank is never refused
   a_r10_no_nak_when_ready: assert property (@(posedge clk) disable iff (rst)
      (en && st_q == ENG_IDLE && tok_in && released[eng_ptr_q]) |=> !tok_nak);
   // R11: the final byte leads to the ACK wait
   a_r11_last_to_wait: assert property (@(posedge clk) disable iff (rst)
      (en && tx_last) |=> (st_q == ENG_WAIT));
   // R13: an ACK ends the packet
   a_r13_ack_to_idle: assert property (@(posedge clk) disable iff (rst)
      free_pulse |=> (st_q == ENG_IDLE));
endmodule

// File: rtl/usb_in_ep_bank_ctrl.sv
module usb_in_ep_bank_ctrl #(
   parameter int DATA_W     = 8,
   parameter int BANK_BYTES = 8,
   parameter int NUM_BANKS  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_enable,
   input  logic              cfg_dual,
   input  logic              cpu_int_en,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_clr_ready,
   input  logic              cpu_release,
   output logic              st_ready,
   output logic              st_own,
   output logic              st_rw_ok,
   output logic              ep_irq,
   output logic              err_release,
   output logic              err_overflow,
   input  logic              tok_in,
   output logic              tok_nak,
   input  logic              host_ack,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_last,
   output logic              tx_zlp
);
   localparam int CNT_W = $clog2(BANK_BYTES + 1);
   localparam int IDX_W = $clog2(BANK_BYTES);

   if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
      $error("NUM_BANKS must be 1 or 2");
   end
   if (BANK_BYTES < 2) begin : g_bad_depth
      $error("BANK_BYTES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic dual;
   if (NUM_BANKS == 2) begin : g_two
      assign dual = cfg_dual;
   end else begin : g_one
      logic unused_dual;
      assign unused_dual = cfg_dual;
      assign dual        = 1'b0;
   end

   logic                  wr_accept, fw_ptr, eng_ptr, free_pulse, ready_int;
   logic [1:0]            released;
   logic [1:0][CNT_W-1:0] cnt_all;
   logic [IDX_W-1:0]      rd_idx;

   inep_fw_ctrl #(.DEPTH(BANK_BYTES), .CNT_W(CNT_W)) fw_i (
      .clk(clk), .rst(rst), .en(cfg_enable), .dual(dual),
      .wr_req(cpu_wr), .clr_ready(cpu_clr_ready), .release_req(cpu_release),
      .free_pulse(free_pulse), .free_bank(eng_ptr), .cnt_cur(cnt_all[fw_ptr]),
      .own_o(st_own), .ready_o(ready_int), .rw_ok_o(st_rw_ok),
      .rel_err_o(err_release), .ovf_o(err_overflow), .wr_accept_o(wr_accept),
      .fw_ptr_o(fw_ptr), .released_o(released)
   );

   inep_bank_store #(.DATA_W(DATA_W), .DEPTH(BANK_BYTES), .NUM_BANKS(NUM_BANKS),
                     .CNT_W(CNT_W), .IDX_W(IDX_W)) store_i (
      .clk(clk), .rst(rst), .clear_all(!cfg_enable),
      .wr_en(wr_accept), .wr_bank(fw_ptr), .wr_data(cpu_wdata),
      .clr_en(free_pulse), .clr_bank(eng_ptr),
      .rd_bank(eng_ptr), .rd_idx(rd_idx), .rd_data(tx_data), .cnt_o(cnt_all)
   );

   inep_tx_engine #(.CNT_W(CNT_W), .IDX_W(IDX_W)) eng_i (
      .clk(clk), .rst(rst), .en(cfg_enable), .dual(dual),
      .tok_in(tok_in), .host_ack(host_ack), .released(released), .cnt_all(cnt_all),
      .eng_ptr_o(eng_ptr), .rd_idx_o(rd_idx), .tx_valid(tx_valid), .tx_last(tx_last),
      .tx_zlp(tx_zlp), .tok_nak(tok_nak), .free_pulse(free_pulse)
   );

   assign st_ready = ready_int;
   assign ep_irq   = ready_int && cpu_int_en;

   // R3: interrupt follows the ready flag and its enable
   a_r3_irq_gate: assert property (@(posedge clk) disable iff (rst)
      ep_irq |-> (st_ready && cpu_int_en));
endmodule

// File: tb/usb_in_ep_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_in_ep_bank_ctrl_tb_top;
   localparam int D = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 0, dual = 0, int_en = 0, wr = 0, clr = 0, rel = 0, tok = 0, ack = 0;
   logic [7:0] wdata = 8'h00;
   logic st_ready, st_own, st_rw_ok, ep_irq, err_release, err_overflow;
   logic tok_nak, tx_valid, tx_last, tx_zlp;
   logic [7:0] tx_data;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit done    = 0;

   always #4 clk = ~clk;

   usb_in_ep_bank_ctrl #(.DATA_W(8), .BANK_BYTES(D), .NUM_BANKS(2)) dut_i (
      .clk(clk), .rst(rst), .cfg_enable(en), .cfg_dual(dual), .cpu_int_en(int_en),
      .cpu_wr(wr), .cpu_wdata(wdata), .cpu_clr_ready(clr), .cpu_release(rel),
      .st_ready(st_ready), .st_own(st_own), .st_rw_ok(st_rw_ok), .ep_irq(ep_irq),
      .err_release(err_release), .err_overflow(err_overflow),
      .tok_in(tok), .tok_nak(tok_nak), .host_ack(ack),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp)
   );

   // behavioural reference model
   int m_own, m_ready, m_fwp, m_engp, m_est, m_ridx, m_ovf, m_err, m_nak;
   int m_rel [2];
   int m_cnt [2];
   int m_mem [2][D];

   initial begin
      m_own = 0; m_ready = 0; m_fwp = 0; m_engp = 0; m_est = 0; m_ridx = 0;
      m_ovf = 0; m_err = 0; m_nak = 0;
      m_rel = '{0, 0}; m_cnt = '{0, 0};
   end

   always @(posedge clk) begin
      int rel_ok, keep, own_n;
      if (rst || !en) begin
         m_nak = (!rst && !en && tok) ? 1 : 0;
         m_own = 0; m_ready = 0; m_fwp = 0; m_engp = 0; m_est = 0; m_ridx = 0;
         m_ovf = 0; m_err = 0;
         m_rel = '{0, 0}; m_cnt = '{0, 0};
      end else begin
         rel_ok = (rel && m_own && !m_ready) ? 1 : 0;
         m_err  = (rel && !rel_ok) ? 1 : 0;
         if (wr) begin
            if (m_own && m_cnt[m_fwp] < D) begin
               m_mem[m_fwp][m_cnt[m_fwp]] = int'(wdata);
               m_cnt[m_fwp]++;
            end else m_ovf = 1;
         end
         m_nak = 0;
         if (m_est == 0) begin
            if (tok) begin
               if (m_rel[m_engp] != 0) begin m_est = 1; m_ridx = 0; end
               else m_nak = 1;
            end
         end else if (m_est == 1) begin
            if (m_cnt[m_engp] == 0 || m_ridx == m_cnt[m_engp] - 1) m_est = 2;
            else m_ridx++;
         end else if (ack) begin
            m_rel[m_engp] = 0;
            m_cnt[m_engp] = 0;
            if (dual) m_engp = 1 - m_engp;
            m_est = 0;
         end
         if (rel_ok != 0) begin
            m_rel[m_fwp] = 1;
            if (dual) m_fwp = 1 - m_fwp;
         end
         keep  = (m_own != 0 && rel_ok == 0) ? 1 : 0;
         own_n = (keep != 0 || m_rel[m_fwp] == 0) ? 1 : 0;
         if (own_n != 0 && keep == 0) m_ready = 1;
         else if (clr) m_ready = 0;
         m_own = own_n;
      end
   end

   task automatic chk(input logic act, input int exp, input string tag);
      n_tests++;
      if (act !== exp[0]) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic chk8(input logic [7:0] act, input int exp, input string tag);
      n_tests++;
      if (act !== exp[7:0]) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h at cycle %0d", tag, act, exp[7:0], cycles);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) begin
      cycles++;
      if (!rst && !done) begin
         chk(st_ready,     m_ready, "R2 ready");
         chk(st_own,       m_own, "R6 own");
         chk(st_rw_ok,     (m_own != 0 && m_cnt[m_fwp] < D) ? 1 : 0, "R8 rw_ok");
         chk(ep_irq,       (m_ready != 0 && int_en) ? 1 : 0, "R3 irq");
         chk(err_overflow, m_ovf, "R9 overflow");
         chk(err_release,  m_err, "R5 release_err");
         chk(tok_nak,      m_nak, "R10 nak");
         chk(tx_valid,     (m_est == 1 && m_cnt[m_engp] > 0) ? 1 : 0, "R11 valid");
         chk(tx_last,      (m_est == 1 && m_cnt[m_engp] > 0 && m_ridx == m_cnt[m_engp] - 1) ? 1 : 0, "R11 last");
         chk(tx_zlp,       (m_est == 1 && m_cnt[m_engp] == 0) ? 1 : 0, "R12 zlp");
         if (tx_valid) chk8(tx_data, m_mem[m_engp][m_ridx], "R14 data");
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic wbyte(input logic [7:0] v);
      wr = 1; wdata = v; tick(); wr = 0;
   endtask

   initial begin
      tick(); tick(); tick();
      rst = 0;
      chk(st_ready, 0, "R1 ready off"); chk(st_own, 0, "R1 own off"); chk(ep_irq, 0, "R1 irq off");
      tok = 1; tick(); tok = 0;
      chk(tok_nak, 1, "R1 nak while off");

      en = 1; int_en = 1; tick();
      chk(st_ready, 1, "R2 ready on enable"); chk(st_own, 1, "R2 own on enable");
      chk(ep_irq, 1, "R3 irq");

      rel = 1; tick(); rel = 0;
      chk(err_release, 1, "R5 early release"); chk(st_own, 1, "R5 own kept");
      tok = 1; tick(); tok = 0;
      chk(tok_nak, 1, "R5 bank not sent");

      clr = 1; tick(); clr = 0;
      chk(st_ready, 0, "R4 ready cleared"); chk(st_own, 1, "R4 own kept"); chk(ep_irq, 0, "R3 irq low");

      tok = 1; tick(); tok = 0;
      chk(tok_nak, 1, "R10 nak empty");

      wbyte(8'hA1); wbyte(8'hA2); wbyte(8'hA3);
      rel = 1; tick(); rel = 0;
      chk(st_own, 0, "R6 own released"); chk(st_ready, 0, "R6 ready low");
      tok = 1; tick(); tok = 0;
      chk(tx_valid, 1, "R11 stream start"); chk8(tx_data, 8'hA1, "R11 first byte");
      tick(); tick(); tick(); tick();
      chk(st_own, 0, "R6 own low until ack");
      ack = 1; tick(); ack = 0;
      chk(st_own, 1, "R13 own back"); chk(st_ready, 1, "R13 ready back");

      clr = 1; tick(); clr = 0;
      for (int i = 0; i < D; i++) wbyte(8'(8'h30 + i));
      chk(st_rw_ok, 0, "R8 full");
      chk(err_overflow, 0, "R9 no overflow yet");
      wbyte(8'hFF);
      chk(err_overflow, 1, "R9 overflow set");
      rel = 1; tick(); rel = 0;
      tok = 1; tick(); tok = 0;
      for (int i = 0; i < D + 1; i++) tick();
      ack = 1; tick(); ack = 0;
      clr = 1; tick(); clr = 0;
      chk(err_overflow, 1, "R9 sticky");

      rel = 1; tick(); rel = 0;
      tok = 1; tick(); tok = 0;
      chk(tx_zlp, 1, "R12 zlp"); chk(tx_valid, 0, "R12 no data");
      tick();
      ack = 1; tick(); ack = 0;

      en = 0; tick();
      chk(err_overflow, 0, "R1 overflow cleared");
      dual = 1; en = 1; tick();
      clr = 1; tick(); clr = 0;
      wbyte(8'h10); wbyte(8'h11);
      rel = 1; tick(); rel = 0;
      chk(st_own, 1, "R7 own stays"); chk(st_ready, 1, "R7 ready set again");
      clr = 1; tick(); clr = 0;
      wbyte(8'h20);
      rel = 1; tick(); rel = 0;
      chk(st_own, 0, "R7 both banks out");
      tok = 1; tick(); tok = 0;
      chk8(tx_data, 8'h10, "R14 first bank first");
      tick(); tick();
      ack = 1; tick(); ack = 0;
      chk(st_own, 1, "R13 dual own back");
      tok = 1; tick(); tok = 0;
      chk8(tx_data, 8'h20, "R14 second bank next");
      tick(); tick();
      ack = 1; tick(); ack = 0;
      tick(); tick();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule